// File: doc/BRIEF.md
# Infrared Receive Glitch Filter

This block cleans one line of an infrared receiver before the line reaches the logic that monitors it. One bit is picked from an input bus by an index and brought into the clock domain through a chain of synchronizer flops. The filter forwards a new level only after that level has stayed unchanged for longer than a programmable minimum width. Shorter excursions never reach the output.

The minimum width is chosen with a 3-bit code. With the default step of 54 cycles at 108 MHz, the codes cover 0.5 µs to 4.0 µs in 0.5 µs increments. Because of the wait, the filtered bit lags the raw line by the selected width. It therefore lags any bus bit that other logic samples without filtering, and users must allow for that skew.

Filtering is active only when the enable is high and the transmit-mode select is low. In every other setting the synchronized bit goes straight to the output.

Top module: `ir_pulse_filter`

## Requirements
- R1: The width threshold is (code+1)×STEP_CYCLES clock cycles, where code is the 3-bit `width_code_i`. STEP_CYCLES defaults to 54, which makes 54 to 432 cycles at 108 MHz.
- R2: While filtering is active, a level that the selected input holds for more than the threshold (threshold+1 cycles or more) appears at the output. A level held for the threshold or fewer cycles never appears.
- R3: While filtering is active, a passed level change on the bus shows at `filt_o` exactly threshold+3 clock edges after the first edge that samples it: two synchronizer edges, then threshold+1 counting edges.
- R4: With `filt_en_i` low, `filt_o` follows the selected bit with a two-edge latency, whatever the pulse width.
- R5: With `tx_mode_i` high, the filter is bypassed exactly as in R4, whatever the value of `filt_en_i`.
- R6: `sel_i` picks bus bit `bus_i[sel_i]`, and the other bus bits have no effect on the output. An index at or above the bus width selects a constant low.
- R7: A change of `width_code_i` while a level change is being timed does not alter that count. The new code applies from the next change of the input level.
- R8: While reset is asserted, and right after it is released, `filt_o` is low and the width counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Filter clock (108 MHz nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| filt_en_i | input | 1 | Enables the width filter |
| tx_mode_i | input | 1 | Transmit-mode select; high forces bypass |
| width_code_i | input | 3 | Minimum-width code |
| sel_i | input | SEL_W (8) | Index of the bus bit to filter |
| bus_i | input | BUS_W (8) | Raw input bus |
| filt_o | output | 1 | Filtered (or bypassed) selected bit |

## Verification
The bench builds the block with STEP_CYCLES set to 4, so the eight codes span 4 to 32 cycles. At that size the lowest and highest codes, and the pulse lengths just above and just below each threshold, can all be exercised within a few hundred cycles. The bus and index stay at their default width of 8. With an 8-bit index, values above 7 can be applied, which makes the out-of-range case reachable. The small step also lets a code change be applied partway through a timed pulse and then take effect on the following pulse.

// File: rtl/ir_filt_pkg.sv
package ir_filt_pkg;
  localparam int unsigned CODE_W    = 3;
  localparam int unsigned NUM_CODES = 1 << CODE_W;

  typedef logic [CODE_W-1:0] width_code_t;

  function automatic int unsigned code_to_cycles(input width_code_t code,
                                                 input int unsigned step);
    return (int'(code) + 1) * step;
  endfunction
endpackage

// File: rtl/ir_bit_select.sv
module ir_bit_select #(
  parameter int unsigned BUS_W       = 8,
  parameter int unsigned SEL_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [BUS_W-1:0] bus_i,
  output logic             sync_o
);
  logic raw_bit;
  logic [SYNC_STAGES-1:0] chain_q;

  // out-of-range index reads constant low
  always_comb begin
    raw_bit = 1'b0;
    for (int i = 0; i < BUS_W; i++) begin
      if (sel_i == SEL_W'(i)) raw_bit = bus_i[i];
    end
  end

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= 1'b0;
      else if (s == 0) chain_q[s] <= raw_bit;
      else chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_o = chain_q[SYNC_STAGES-1];
endmodule

// File: rtl/ir_width_timer.sv
module ir_width_timer
  import ir_filt_pkg::*;
#(
  parameter int unsigned STEP_CYCLES = 54,
  parameter int unsigned CNT_W       = $clog2(NUM_CODES*STEP_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             din_i,
  input  width_code_t      code_i,
  output logic             filt_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] thr_o
);
  logic [CNT_W-1:0] cnt_q, thr_q, thr_new;
  logic             filt_q;

  assign thr_new = CNT_W'(code_to_cycles(code_i, STEP_CYCLES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q <= 1'b0;
      cnt_q  <= '0;
      thr_q  <= CNT_W'(STEP_CYCLES);
    end else if (!active_i) begin
      // bypass: track input so re-enable is glitch free
      filt_q <= din_i;
      cnt_q  <= '0;
      thr_q  <= thr_new;
    end else if (din_i == filt_q) begin
      // idle: threshold may follow the code only here
      cnt_q  <= '0;
      thr_q  <= thr_new;
    end else if (cnt_q == thr_q) begin
      filt_q <= din_i;
      cnt_q  <= '0;
    end else begin
      cnt_q  <= cnt_q + CNT_W'(1);
    end
  end

  assign filt_o = filt_q;
  assign cnt_o  = cnt_q;
  assign thr_o  = thr_q;
endmodule

// File: rtl/ir_pulse_filter.sv
module ir_pulse_filter
  import ir_filt_pkg::*;
#(
  parameter int unsigned BUS_W       = 8,
  parameter int unsigned SEL_W       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STEP_CYCLES = 54
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             filt_en_i,
  input  logic             tx_mode_i,
  input  logic [2:0]       width_code_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [BUS_W-1:0] bus_i,
  output logic             filt_o
);
  localparam int unsigned CNT_W = $clog2(NUM_CODES*STEP_CYCLES + 1);

  logic             sync_bit;
  logic             filt_bit;
  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] thr;

  assign active = filt_en_i && !tx_mode_i;

  ir_bit_select #(
    .BUS_W      (BUS_W),
    .SEL_W      (SEL_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sel (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (sel_i),
    .bus_i (bus_i),
    .sync_o(sync_bit)
  );

  ir_width_timer #(
    .STEP_CYCLES(STEP_CYCLES),
    .CNT_W      (CNT_W)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(active),
    .din_i   (sync_bit),
    .code_i  (width_code_t'(width_code_i)),
    .filt_o  (filt_bit),
    .cnt_o   (cnt),
    .thr_o   (thr)
  );

  assign filt_o = active ? filt_bit : sync_bit;
endmodule

// File: rtl/ir_pulse_filter_chk.sv
module ir_pulse_filter_chk #(
  parameter int unsigned STEP_CYCLES = 54,
  parameter int unsigned NUM_CODES   = 8,
  parameter int unsigned CNT_W       = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             active,
  input logic             sync_bit,
  input logic             filt_bit,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] thr,
  input logic             filt_o
);
  AST_THR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(thr) >= int'(STEP_CYCLES)) && (int'(thr) <= int'(NUM_CODES*STEP_CYCLES))
    && (int'(thr) % int'(STEP_CYCLES) == 0)); // R1

  AST_FLIP_AT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && $past(active) && filt_o != $past(filt_o)) |-> ($past(cnt) == $past(thr))); // R2

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= thr); // R2

  AST_CNT_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && sync_bit == filt_bit) |=> (cnt == '0)); // R2

  AST_BYPASS_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> (filt_bit == $past(sync_bit))); // R4

  AST_THR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && sync_bit != filt_bit) |=> $stable(thr)); // R7
endmodule

bind ir_pulse_filter ir_pulse_filter_chk #(
  .STEP_CYCLES(STEP_CYCLES),
  .NUM_CODES  (ir_filt_pkg::NUM_CODES),
  .CNT_W      (CNT_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .active  (active),
  .sync_bit(sync_bit),
  .filt_bit(filt_bit),
  .cnt     (cnt),
  .thr     (thr),
  .filt_o  (filt_o)
);

// File: tb/sim_ir_pulse_filter.sv
`timescale 1ns/1ps
module sim_ir_pulse_filter;
  localparam int STEP = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       tx = 1'b0;
  logic [2:0] code = 3'd0;
  logic [7:0] sel = 8'd0;
  logic [7:0] bus = 8'd0;
  logic       fo;

  int cyc = 0;
  int checks = 0;
  int errors = 0;

  typedef struct {
    int    due;
    logic  exp;
    string req;
  } item_t;
  item_t sbq[$];
  item_t mon_it;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ir_pulse_filter #(.STEP_CYCLES(STEP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .filt_en_i(en), .tx_mode_i(tx),
    .width_code_i(code), .sel_i(sel), .bus_i(bus), .filt_o(fo)
  );

  task automatic push(input int due, input logic exp, input string req);
    item_t it;
    it.due = due; it.exp = exp; it.req = req;
    sbq.push_back(it);
  endtask

  // monitor: compare due items at the falling edge
  always @(negedge clk) begin
    while (sbq.size() != 0 && sbq[0].due <= cyc) begin
      mon_it = sbq.pop_front();
      checks++;
      if (mon_it.due != cyc || fo !== mon_it.exp) begin
        errors++;
        $display("FAIL %s cycle %0d: actual=%b expected=%b (due %0d)",
                 mon_it.req, cyc, fo, mon_it.exp, mon_it.due);
      end
    end
  end

  function automatic int thr_of(input logic [2:0] c);
    return (int'(c) + 1) * STEP;
  endfunction

  // drives one high pulse on bus[idx] and schedules the expected output
  task automatic pulse(input int idx, input int len, input int thr,
                       input bit filt, input string req);
    int n;
    @(posedge clk); #1;
    n = cyc;
    bus[idx] = 1'b1;
    if (!filt) begin
      push(n+1, 1'b0, req); push(n+2, 1'b1, req);
      push(n+len+1, 1'b1, req); push(n+len+2, 1'b0, req);
    end else if (len > thr) begin
      push(n+2+thr, 1'b0, req); push(n+3+thr, 1'b1, req);
      push(n+len+2+thr, 1'b1, req); push(n+len+3+thr, 1'b0, req);
    end else begin
      push(n+len+2, 1'b0, req); push(n+3+thr, 1'b0, req);
    end
    repeat (len) @(posedge clk);
    #1 bus[idx] = 1'b0;
    repeat (thr + 8) @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    // R8: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (fo !== 1'b0) begin
      errors++; $display("FAIL R8 in reset: actual=%b expected=0", fo);
    end
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (fo !== 1'b0 || u0.cnt !== '0) begin
      errors++; $display("FAIL R8 after reset: actual=%b expected=0", fo);
    end
    en = 1'b1;
    repeat (4) @(posedge clk);

    // R1 R2 R3: code 0, threshold 4
    code = 3'd0; sel = 8'd0;
    repeat (3) @(posedge clk);
    pulse(0, thr_of(3'd0) + 1, thr_of(3'd0), 1'b1, "R3");
    pulse(0, thr_of(3'd0),     thr_of(3'd0), 1'b1, "R2");
    pulse(0, 1,                thr_of(3'd0), 1'b1, "R2");

    // R1: mid code 3, threshold 16
    code = 3'd3;
    repeat (3) @(posedge clk);
    pulse(0, thr_of(3'd3) + 1, thr_of(3'd3), 1'b1, "R1");
    pulse(0, thr_of(3'd3),     thr_of(3'd3), 1'b1, "R1");

    // R1 R2: top code 7, threshold 32
    code = 3'd7;
    repeat (3) @(posedge clk);
    pulse(0, thr_of(3'd7) + 1, thr_of(3'd7), 1'b1, "R1");
    pulse(0, thr_of(3'd7),     thr_of(3'd7), 1'b1, "R2");

    // R7: code change mid-count is ignored
    @(posedge clk); #1;
    n = cyc;
    bus[0] = 1'b1;
    push(n+7, 1'b0, "R7"); push(n+12, 1'b0, "R7"); push(n+20, 1'b0, "R7");
    repeat (5) @(posedge clk);
    #1 code = 3'd0;
    repeat (5) @(posedge clk);
    #1 bus[0] = 1'b0;
    repeat (20) @(posedge clk);
    // R7: new code applies on the next transition
    pulse(0, thr_of(3'd0) + 1, thr_of(3'd0), 1'b1, "R7");

    // R6: other bus bits have no effect; selected bit works
    sel = 8'd5;
    repeat (4) @(posedge clk);
    @(posedge clk); #1;
    n = cyc;
    bus[2:0] = 3'b111; bus[7] = 1'b1;
    push(n+10, 1'b0, "R6"); push(n+20, 1'b0, "R6");
    repeat (22) @(posedge clk);
    #1 bus = 8'd0;
    repeat (6) @(posedge clk);
    pulse(5, thr_of(3'd0) + 2, thr_of(3'd0), 1'b1, "R6");

    // R6: out-of-range index reads low
    sel = 8'd9;
    @(posedge clk); #1;
    n = cyc;
    bus = 8'hFF;
    push(n+8, 1'b0, "R6"); push(n+16, 1'b0, "R6");
    repeat (18) @(posedge clk);
    #1 bus = 8'd0;
    sel = 8'd0;
    repeat (6) @(posedge clk);

    // R4: enable low bypasses, short pulse passes
    en = 1'b0;
    repeat (4) @(posedge clk);
    pulse(0, 2, thr_of(3'd0), 1'b0, "R4");
    pulse(0, 1, thr_of(3'd0), 1'b0, "R4");

    // R5: transmit mode bypasses even with enable high
    en = 1'b1; tx = 1'b1; code = 3'd7;
    repeat (4) @(posedge clk);
    pulse(0, 3, 8, 1'b0, "R5");
    tx = 1'b0;
    repeat (4) @(posedge clk);
    // back to filtering with code 7
    pulse(0, 3, thr_of(3'd7), 1'b1, "R2");

    repeat (10) @(posedge clk);
    if (sbq.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL R3 pending items: actual=%0d expected=0", sbq.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule